// File: doc/BRIEF.md
# Round-Robin Output Port Allocator

This block owns one output port of a circuit-switched router. Every input channel that is allowed to reach the port raises a request line. When the port is free, the allocator picks one requester with rotating priority. It then reserves the port for that requester as a circuit: the one-hot select that steers the transport multiplexer stays on the winner until a release arrives. Requests that reach a held port are not queued. Each one is answered with a reject, and the requester may withdraw and try again later.

Arbitration and locking complete in one clock edge. Teardown also takes one edge, and the port can be granted to another requester on the edge after that. Each output port has its own instance, so a port that is locked has no effect on the arbitration of the other ports. Address decoding and the data path are outside this block.

Top module: `rr_port_alloc`

## Requirements
- R1: While reset is asserted and after reset, `sel_o`, `grant_o` and `reject_o` are all zero. The rotation pointer starts so that requester 0 has the highest priority.
- R2: When the port is free and exactly one request bit `k` is high at a clock edge, then after that edge `grant_o` has only bit `k` set for one cycle, and `sel_o` has only bit `k` set.
- R3: When the port is free and several requests are high, the winner is the first asserted requester found by searching cyclically upward from the index after the last winner. Requesters that lose in that cycle have their reject bit set in the cycle that follows.
- R4: The rotation pointer changes only when a grant is made. Idle cycles, held cycles and release cycles leave it unchanged.
- R5: Once a requester is selected, `sel_o` keeps its value on every edge at which `release_i` is low, whatever the request lines do, including the owner's own request.
- R6: While the port is held and `release_i` is low, each requester other than the owner that has its request high at an edge gets its `reject_o` bit set for the following cycle, and `grant_o` stays zero.
- R7: An edge with `release_i` high while the port is held clears `sel_o`. That edge produces no grant and no reject, and a request at the next edge can be granted.
- R8: For every requester, grant and reject are never high in the same cycle. `sel_o` and `grant_o` each have at most one bit set.
- R9: `release_i` high while the port is free has no effect on any output or on the priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_REQ | One request line per input channel |
| release_i | input | 1 | Tears down the circuit that holds the port |
| sel_o | output | N_REQ | One-hot select for the transport multiplexer; zero when the port is free |
| grant_o | output | N_REQ | One-cycle pulse to the requester that has just won |
| reject_o | output | N_REQ | One-cycle pulse to each requester that has been refused |

## Verification
Every output is a register, so each result is due in the cycle that follows the edge at which the request or release was sampled. Select, grant and reject are all visible one edge after the stimulus. The bench drives inputs on the falling edge and advances its own model of owner and pointer at the rising edge. It compares the outputs one time unit after that rising edge, so each check looks at the result of exactly one sampled input set. Directed sequences cover rotation, idle gaps, release in the free state and a grant on the edge right after a release. Seeded random traffic covers the remaining cases.

// File: rtl/rr_port_alloc.sv
module rr_port_alloc #(
  parameter int N_REQ = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req_i,
  input  logic             release_i,
  output logic [N_REQ-1:0] sel_o,
  output logic [N_REQ-1:0] grant_o,
  output logic [N_REQ-1:0] reject_o
);
  localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [N_REQ-1:0] owner_q, grant_q, reject_q, win;
  logic [IW-1:0]    last_q, win_idx;
  logic             busy;

  assign busy = |owner_q;

  always_comb begin
    win     = '0;
    win_idx = last_q;
    for (int k = N_REQ; k >= 1; k--) begin
      int j;
      j = (int'(last_q) + k) % N_REQ;
      if (req_i[j]) begin
        win     = '0;
        win[j]  = 1'b1;
        win_idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q  <= '0;
      grant_q  <= '0;
      reject_q <= '0;
      last_q   <= IW'(N_REQ - 1);
    end else begin
      grant_q  <= '0;
      reject_q <= '0;
      if (busy) begin
        if (release_i) owner_q <= '0;
        else reject_q <= req_i & ~owner_q;
      end else if (|req_i) begin
        owner_q  <= win;
        grant_q  <= win;
        reject_q <= req_i & ~win;
        last_q   <= win_idx;
      end
    end
  end

  assign sel_o    = owner_q;
  assign grant_o  = grant_q;
  assign reject_o = reject_q;
endmodule

module rr_port_alloc_chk #(
  parameter int N_REQ = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_REQ-1:0] req_i,
  input logic             release_i,
  input logic [N_REQ-1:0] sel_o,
  input logic [N_REQ-1:0] grant_o,
  input logic [N_REQ-1:0] reject_o
);
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & reject_o) == '0);
  p_sel_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o) && $onehot0(grant_o));
  p_grant_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0) |-> (sel_o == grant_o));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o != '0 && !release_i) |=> (sel_o == $past(sel_o)));
  p_no_grant_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o != '0) |=> (grant_o == '0));
  p_reject_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o != '0 && !release_i) |=> (reject_o == ($past(req_i) & ~$past(sel_o))));
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o != '0 && release_i) |=> (sel_o == '0 && reject_o == '0));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o == '0 && req_i == '0) |=> (sel_o == '0 && grant_o == '0 && reject_o == '0));
endmodule

bind rr_port_alloc rr_port_alloc_chk #(.N_REQ(N_REQ)) u_chk (.*);

// File: tb/sim_rr_port_alloc.sv
module sim_rr_port_alloc;
  localparam int N = 3;
  localparam time TCLK = 10;

  logic clk = 1'b0, rst_n = 1'b0, release_i = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [N-1:0] sel_o, grant_o, reject_o;

  int checks = 0, fails = 0;
  logic [N-1:0] m_owner, e_sel, e_grant, e_rej;
  int m_last;

  always #(TCLK/2) clk = ~clk;

  rr_port_alloc #(.N_REQ(N)) u0 (.*);

  task automatic check(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic step(logic [N-1:0] r, logic rel, string tag);
    @(negedge clk);
    req_i = r; release_i = rel;
    @(posedge clk);
    e_grant = '0; e_rej = '0;
    if (m_owner != '0) begin
      if (rel) m_owner = '0;
      else e_rej = r & ~m_owner;
    end else if (r != '0) begin
      for (int k = 1; k <= N; k++) begin
        int j;
        j = (m_last + k) % N;
        if (r[j] && e_grant == '0) begin e_grant[j] = 1'b1; m_last = j; end
      end
      m_owner = e_grant;
      e_rej = r & ~e_grant;
    end
    e_sel = m_owner;
    #1;
    check(tag, "sel", sel_o, e_sel);
    check(tag, "grant", grant_o, e_grant);
    check(tag, "reject", reject_o, e_rej);
  endtask

  initial begin
    #(TCLK * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    m_owner = '0; m_last = N - 1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "sel", sel_o, '0);
    check("R1", "grant", grant_o, '0);
    check("R1", "reject", reject_o, '0);
    @(negedge clk); rst_n = 1'b1;

    step(3'b000, 1'b1, "R9");
    step(3'b010, 1'b0, "R2");
    step(3'b000, 1'b0, "R5");
    step(3'b101, 1'b0, "R6");
    step(3'b111, 1'b0, "R6");
    step(3'b101, 1'b1, "R7");
    step(3'b101, 1'b0, "R7");
    step(3'b000, 1'b1, "R7");
    step(3'b000, 1'b0, "R4");
    step(3'b000, 1'b1, "R9");
    step(3'b111, 1'b0, "R3");
    step(3'b000, 1'b1, "R7");
    step(3'b111, 1'b0, "R3");
    step(3'b000, 1'b1, "R7");
    step(3'b111, 1'b0, "R4");
    step(3'b011, 1'b0, "R5");
    step(3'b000, 1'b1, "R7");

    void'($urandom(32'd4242));
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] r;
      r = N'($urandom);
      step(r, ($urandom % 4) == 0, "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule